// File: doc/BRIEF.md
# CPU status flag register

This block holds the processor status word of a small 16-bit core. Its low byte carries four arithmetic result flags (carry, zero, sign, overflow) and four control flags (single-step, register bank select, interrupt enable, stack pointer select). Bits 8 to 15 are reserved and always read as zero.

The flags change from three sources. The ALU updates any subset of the result flags through one write enable per flag. Software writes the whole register. Interrupt entry clears control flags. A hardware interrupt acknowledge clears interrupt enable, single-step and stack select. A software interrupt always clears interrupt enable and single-step, but it clears stack select only for vector numbers below 32. While the single-step flag is set, every retired instruction raises a one-cycle trap request. The exception is the retire that performs interrupt entry.

Top module: `cpu_flag_reg`

## Requirements
- R1: After reset `flags` reads 0x0000, and `bank_sel`, `stack_sel`, `int_en` and `step_req` are 0.
- R2: On a clock edge where `alu_we[k]` is 1, the flag selected by bit k takes `alu_res[k]`. The mapping is k=0 to carry (bit 0), k=1 to zero (bit 2), k=2 to sign (bit 3) and k=3 to overflow (bit 5). A result flag whose enable is 0 keeps its value.
- R3: `wr_en` loads `wr_data[7:0]` into flag bits 7:0. Bits 15:8 of `flags` always read 0, whatever value is written.
- R4: When `wr_en` and an ALU update share a cycle, each ALU-enabled result flag takes the ALU value. Every other bit takes the written value.
- R5: `hw_ack` clears interrupt enable (bit 6), single-step (bit 1) and stack select (bit 7), even when a write sets them in the same cycle. Bank select (bit 4) is not affected.
- R6: `sw_int` clears bits 6 and 1. It clears bit 7 only when `sw_vec` is below 32; otherwise bit 7 follows the normal write or hold rule.
- R7: `bank_sel`, `int_en` and `stack_sel` are copies of flag bits 4, 6 and 7 respectively.
- R8: `step_req` is 1, combinationally within the same cycle, exactly when `retire` is 1, the single-step flag (bit 1) is 1, and neither `hw_ack` nor `sw_int` is 1.
- R9: An ALU result-flag update applied in the same cycle as an interrupt entry takes effect unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_we | input | 4 | Per-flag ALU enables: bit 0 carry, bit 1 zero, bit 2 sign, bit 3 overflow |
| alu_res | input | 4 | ALU flag values, in the same order as `alu_we` |
| wr_en | input | 1 | Full register write |
| wr_data | input | 16 | Write data |
| retire | input | 1 | Instruction retire strobe |
| hw_ack | input | 1 | Hardware interrupt acknowledge |
| sw_int | input | 1 | Software interrupt entry |
| sw_vec | input | 6 | Software interrupt vector number |
| flags | output | 16 | Register value |
| bank_sel | output | 1 | Register bank select |
| stack_sel | output | 1 | 0: interrupt stack pointer, 1: user stack pointer |
| int_en | output | 1 | Maskable interrupt enable |
| step_req | output | 1 | Single-step trap request |

## Verification
The collision of interest is interrupt entry against an ALU update or a register write in the same cycle. Entry must win on the control bits it clears, while the result flags still take their ALU values. Random cycles fire `hw_ack`, `sw_int`, `wr_en` and the ALU enables independently, with vectors drawn on both sides of 32, so these overlaps occur often. Directed cases write all ones during each kind of entry. Every register value is compared with a bench model that applies the write first, then the ALU enables, then the entry clears. `step_req` is judged against the pre-edge single-step flag, including retires that coincide with an entry.

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg #(
  parameter int VEC_W      = 6,
  parameter int SW_CLR_LIM = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       alu_we,
  input  logic [3:0]       alu_res,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             retire,
  input  logic             hw_ack,
  input  logic             sw_int,
  input  logic [VEC_W-1:0] sw_vec,
  output logic [15:0]      flags,
  output logic             bank_sel,
  output logic             stack_sel,
  output logic             int_en,
  output logic             step_req
);
  localparam int BC = 0, BD = 1, BZ = 2, BS = 3, BB = 4, BO = 5, BI = 6, BU = 7;
  localparam logic [VEC_W:0] LIM = SW_CLR_LIM[VEC_W:0];

  logic [7:0] flg, nxt;
  logic       entry, u_clr;

  assign entry = hw_ack | sw_int;
  assign u_clr = hw_ack | (sw_int & ({1'b0, sw_vec} < LIM));

  always_comb begin
    nxt = wr_en ? wr_data[7:0] : flg;
    if (alu_we[0]) nxt[BC] = alu_res[0];
    if (alu_we[1]) nxt[BZ] = alu_res[1];
    if (alu_we[2]) nxt[BS] = alu_res[2];
    if (alu_we[3]) nxt[BO] = alu_res[3];
    if (entry) begin
      nxt[BI] = 1'b0;
      nxt[BD] = 1'b0;
    end
    if (u_clr) nxt[BU] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flg <= '0;
    else        flg <= nxt;
  end

  assign flags     = {8'h00, flg};
  assign bank_sel  = flg[BB];
  assign stack_sel = flg[BU];
  assign int_en    = flg[BI];
  assign step_req  = retire & flg[BD] & ~entry;

  // R5
  hw_entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ack |=> (!int_en && !flags[1] && !stack_sel));
  // R6
  sw_entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_int && sw_vec < SW_CLR_LIM[VEC_W-1:0]) |=> (!int_en && !flags[1] && !stack_sel));
  // R2
  alu_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alu_we[0] |=> (flags[0] == $past(alu_res[0])));
  // R9
  alu_ovf_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we[3] && entry) |=> (flags[5] == $past(alu_res[3])));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && alu_we == 4'h0 && !entry) |=> $stable(flags));
  // R8
  step_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry |-> !step_req);
endmodule

// File: tb/sim_cpu_flag_reg.sv
module sim_cpu_flag_reg;
  logic clk = 0, rst_n = 0;
  logic [3:0] alu_we = 0, alu_res = 0;
  logic wr_en = 0, retire = 0, hw_ack = 0, sw_int = 0;
  logic [15:0] wr_data = 0;
  logic [5:0] sw_vec = 0;
  logic [15:0] flags;
  logic bank_sel, stack_sel, int_en, step_req;
  logic [7:0] model = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  cpu_flag_reg u0 (.clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_res(alu_res),
    .wr_en(wr_en), .wr_data(wr_data), .retire(retire), .hw_ack(hw_ack),
    .sw_int(sw_int), .sw_vec(sw_vec), .flags(flags), .bank_sel(bank_sel),
    .stack_sel(stack_sel), .int_en(int_en), .step_req(step_req));

  function automatic logic [7:0] next_model(logic [7:0] cur);
    logic [7:0] n;
    n = wr_en ? wr_data[7:0] : cur;
    if (alu_we[0]) n[0] = alu_res[0];
    if (alu_we[1]) n[2] = alu_res[1];
    if (alu_we[2]) n[3] = alu_res[2];
    if (alu_we[3]) n[5] = alu_res[3];
    if (hw_ack || sw_int) begin n[6] = 0; n[1] = 0; end
    if (hw_ack || (sw_int && sw_vec < 32)) n[7] = 0;
    return n;
  endfunction

  function automatic logic exp_step(logic [7:0] cur);
    return retire && cur[1] && !hw_ack && !sw_int;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    chk(req, {16'h0, flags}, {24'h0, model});
    chk("R7", {29'h0, bank_sel, int_en, stack_sel}, {29'h0, model[4], model[6], model[7]});
  endtask

  task automatic idle();
    alu_we = 0; wr_en = 0; retire = 0; hw_ack = 0; sw_int = 0;
  endtask

  task automatic step(string req);
    #2;
    chk("R8", {31'h0, step_req}, {31'h0, exp_step(model)});
    model = next_model(model);
    @(negedge clk);
    check_outs(req);
    idle();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (2) @(negedge clk);
    // R1
    chk("R1", {16'h0, flags}, 32'h0);
    chk("R1", {28'h0, bank_sel, stack_sel, int_en, step_req}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // R3 reserved bits read zero
    wr_en = 1; wr_data = 16'hFFFF; step("R3");
    chk("R3", {16'h0, flags}, 32'h00FF);
    // R5 hw entry beats write, bank kept
    wr_en = 1; wr_data = 16'h00FF; hw_ack = 1; step("R5");
    chk("R5", {16'h0, flags}, 32'h003D);
    // R6 vector 40 keeps stack select
    wr_en = 1; wr_data = 16'h00FF; sw_int = 1; sw_vec = 40; step("R6");
    chk("R6", {16'h0, flags}, 32'h00BD);
    // R6 vector 31 clears it
    wr_en = 1; wr_data = 16'h00FF; sw_int = 1; sw_vec = 31; step("R6");
    chk("R6", {16'h0, flags}, 32'h003D);
    // R4 ALU over write; R9 ALU during entry
    wr_en = 1; wr_data = 16'h0000; alu_we = 4'hF; alu_res = 4'hF; hw_ack = 1; step("R9");
    chk("R4", {16'h0, flags}, 32'h002D);
    // R2 partial enables
    alu_we = 4'b0010; alu_res = 4'b0000; step("R2");
    chk("R2", {16'h0, flags}, 32'h0029);
    // R8 single-step pulse and suppression on entry
    wr_en = 1; wr_data = 16'h0002; step("R3");
    retire = 1; #2; chk("R8", {31'h0, step_req}, 32'h1); #1 retire = 0; #1;
    chk("R8", {31'h0, step_req}, 32'h0);
    retire = 1; hw_ack = 1; step("R8");
    chk("R8", {16'h0, flags}, 32'h0000);
    // random
    for (int i = 0; i < 3000; i++) begin
      alu_we  = 4'($urandom);
      alu_res = 4'($urandom);
      wr_en   = ($urandom % 4) == 0;
      wr_data = 16'($urandom);
      retire  = ($urandom % 2) == 0;
      hw_ack  = ($urandom % 8) == 0;
      sw_int  = ($urandom % 8) == 0;
      sw_vec  = 6'($urandom);
      step("R2");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule